// File: doc/BRIEF.md
# Power-Management Wake and Reset-Cause Register

This block is a single 32-bit power-management register. It latches wake-up and reset-cause events into sticky flags that stay set until software clears them or a power-on reset occurs. After the processor leaves reset, firmware reads the register to learn which event woke it. Five of the events can be masked into a level-sensitive interrupt line to the CPU. Two of them, the watchdog expiry and the external warm-reset pin, are recorded only as reset causes. The register also shows the live lock state of three PLLs and a power-on status level as read-only bits. Writing a one to a write-only bit requests a warm reset, which the block issues as an active-low pulse of fixed length.

External sources arrive asynchronously. Each passes through a two-flop synchronizer. The warm-reset pin, the adaptor-good level, the ring-indicate pin and the active-low wake pin also pass through a debounce filter. The filter accepts a new level only after it has held steady for a set number of consecutive clocks. The RTC and watchdog events are single-cycle pulses that are already in the register's clock domain.

Top module: `pm_event_reg`

## Requirements
- R1: After `rst_n` is held low across a clock edge, all enables and event flags read 0, `cpu_irq` is low and `warm_rst_req_n` is high.
- R2: Bits 15..11 are read/write enables, from bit 15 down: hot-sync, power-fail, RTC, ring-indicate, wake. They hold their value until written.
- R3: Bits 10..4 are sticky event flags, from bit 10 down: hot-sync (bit 10), watchdog (9), warm-reset pin (8), power-fail (7), RTC (6), ring (5), wake (4). Each flag sets when its event occurs and stays set after the event goes away.
- R4: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R5: When a set and a write-one clear land in the same cycle, the flag stays set.
- R6: A debounced input must hold its new level for STABLE_CYCLES (default 4) consecutive clocks after its two-flop synchronizer before it takes effect. A pulse one clock shorter than that is ignored.
- R7: `cpu_irq` is the OR, over the five maskable sources, of flag AND enable. Enabling a source whose flag is already set raises `cpu_irq` in the cycle after the write. Clearing the flag or the enable drops it.
- R8: The watchdog and warm-reset flags never raise `cpu_irq`, whatever the enables hold.
- R9: Writing 1 to bit 16 drives `warm_rst_req_n` low for exactly PULSE_CYCLES (default 8) cycles, starting the cycle after the write. Writing 0 there has no effect. Bit 16 reads as 0.
- R10: Bits 3, 2 and 1 show `pll_lock[2]`, `pll_lock[1]` and `pll_lock[0]`, and bit 0 shows `por_stat`, each through a two-flop synchronizer. Writes do not change them.
- R11: Bits 31..17 read as 0 and ignore writes.
- R12: Flags, including watchdog and warm-reset, survive a warm-reset request. Only `rst_n` clears them without a write.
- R13: The wake flag (bit 4) sets on a debounced low level of `wake_n_pin`. The power-fail flag sets on a debounced low level of `adaptor_ok_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| reg_en | input | 1 | Register access strobe; read data is zero when low |
| reg_we | input | 1 | Write qualifier for the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as the access |
| hotsync_pin | input | 1 | Asynchronous hot-sync request, active high |
| adaptor_ok_pin | input | 1 | Asynchronous adaptor-good level; low means power fail |
| ring_pin | input | 1 | Asynchronous modem ring indicate, active high |
| wake_n_pin | input | 1 | Asynchronous wake request, active low |
| warm_n_pin | input | 1 | Asynchronous external warm-reset pin, active low |
| rtc_evt | input | 1 | Single-cycle RTC wake pulse |
| wdt_evt | input | 1 | Single-cycle watchdog expiry pulse |
| pll_lock | input | 3 | Asynchronous PLL lock levels |
| por_stat | input | 1 | Asynchronous power-on status level |
| cpu_irq | output | 1 | Level-sensitive interrupt to the CPU |
| warm_rst_req_n | output | 1 | Active-low warm-reset request pulse |

## Verification
A flag register that has lost or dropped a bit shows up on the next read of bits 10..4. If the source is enabled, it also shows on `cpu_irq` one cycle after the enable write. A debounce counter that is off by one shows up at the glitch boundary: a pulse of STABLE_CYCLES-1 clocks must leave the flag at 0, and a pulse of STABLE_CYCLES clocks must set it, and both are visible on a read about STABLE_CYCLES+3 clocks after the pulse starts. A fault in the reset-pulse counter changes how many cycles `warm_rst_req_n` stays low, which the bench counts edge by edge after the write.

// File: rtl/pm_evt_pkg.sv
// Package: field positions and widths shared by the power-management
// event register and its checker. Assumes a single 32-bit register word.
package pm_evt_pkg;
    localparam int REG_W       = 32;
    localparam int BIT_WARMREQ = 16;
    localparam int EN_HI       = 15;
    localparam int EN_LO       = 11;
    localparam int NUM_EN      = EN_HI - EN_LO + 1;
    localparam int FLG_HI      = 10;
    localparam int FLG_LO      = 4;
    localparam int NUM_FLG     = FLG_HI - FLG_LO + 1;
    localparam int NUM_PLL     = 3;
    localparam int NUM_DB      = 4;
    // flag indices inside the flag vector (bit 4 of the word is index 0)
    localparam int F_WAKE = 0;
    localparam int F_RING = 1;
    localparam int F_RTC  = 2;
    localparam int F_PF   = 3;
    localparam int F_WARM = 4;
    localparam int F_WDT  = 5;
    localparam int F_HS   = 6;
    // debouncer slot indices
    localparam int D_WAKE = 0;
    localparam int D_RING = 1;
    localparam int D_ADOK = 2;
    localparam int D_WARM = 3;
endpackage

// File: rtl/pm_sync.sv
// Module: multi-stage synchronizer for a bus of independent async levels.
// Assumes each bit is an independent level (no bus coherence required).
module pm_sync #(
    parameter int STAGES = 2,
    parameter int W = 1,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // shift the input through the flop chain, preset to the idle level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pm_debounce.sv
// Module: synchronizes one async level and passes a new value on only after
// it has been stable for STABLE_CYCLES consecutive clocks.
// Assumes STABLE_CYCLES >= 1; the output resets to IDLE.
module pm_debounce #(
    parameter int   SYNC_STAGES   = 2,
    parameter int   STABLE_CYCLES = 4,
    parameter logic IDLE          = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic          synced;
    logic [CW-1:0] cnt;

    pm_sync #(.STAGES(SYNC_STAGES), .W(1), .IDLE(IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
    );

    // count consecutive cycles of disagreement; accept on the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            level <= IDLE;
        end else if (synced == level) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            level <= synced;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pm_rst_stretch.sv
// Module: turns a one-cycle trigger into an active-low pulse of exactly
// PULSE_CYCLES cycles. A trigger during the pulse restarts it.
module pm_rst_stretch #(
    parameter int PULSE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic req_n
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    logic [CW-1:0] cnt;

    // load on trigger, count down to idle
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (trig)       cnt <= CW'(PULSE_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign req_n = (cnt == '0);
endmodule

// File: rtl/pm_event_reg.sv
// Module: power-management wake/reset-cause register. Holds sticky event
// flags (write-one-to-clear, set has priority), interrupt enables, a
// write-only warm-reset request bit and read-only PLL/POR status.
// Assumes rst_n is the power-on reset; the warm-reset request it issues
// does not reach rst_n, so flags survive it.
module pm_event_reg
    import pm_evt_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4,
    parameter int PULSE_CYCLES  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_en,
    input  logic               reg_we,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               hotsync_pin,
    input  logic               adaptor_ok_pin,
    input  logic               ring_pin,
    input  logic               wake_n_pin,
    input  logic               warm_n_pin,
    input  logic               rtc_evt,
    input  logic               wdt_evt,
    input  logic [NUM_PLL-1:0] pll_lock,
    input  logic               por_stat,
    output logic               cpu_irq,
    output logic               warm_rst_req_n
);
    localparam int NUM_RO = NUM_PLL + 2;
    localparam logic [NUM_DB-1:0] DB_IDLE = 4'b1101;

    logic [NUM_DB-1:0]  db_raw;
    logic [NUM_DB-1:0]  db_lvl;
    logic [NUM_RO-1:0]  ro_sync;
    logic [NUM_EN-1:0]  en_q;
    logic [NUM_FLG-1:0] flag_q;
    logic [NUM_FLG-1:0] flag_set;
    logic [NUM_FLG-1:0] flag_clr;
    logic [NUM_EN-1:0]  irq_src;
    logic               wr;
    logic [REG_W-1:0]   word;

    assign wr = reg_en && reg_we;

    // debounced sources
    assign db_raw[D_WAKE] = wake_n_pin;
    assign db_raw[D_RING] = ring_pin;
    assign db_raw[D_ADOK] = adaptor_ok_pin;
    assign db_raw[D_WARM] = warm_n_pin;

    for (genvar i = 0; i < NUM_DB; i++) begin : g_db
        pm_debounce #(
            .SYNC_STAGES(SYNC_STAGES),
            .STABLE_CYCLES(STABLE_CYCLES),
            .IDLE(DB_IDLE[i])
        ) u_db (
            .clk(clk), .rst_n(rst_n), .raw(db_raw[i]), .level(db_lvl[i])
        );
    end

    // synchronize hot-sync, PLL lock and POR status (no debounce)
    pm_sync #(.STAGES(SYNC_STAGES), .W(NUM_RO), .IDLE('0)) u_ro_sync (
        .clk(clk), .rst_n(rst_n),
        .d({hotsync_pin, pll_lock, por_stat}),
        .q(ro_sync)
    );

    // event set conditions, each asserted while its event is present
    always_comb begin
        flag_set         = '0;
        flag_set[F_WAKE] = !db_lvl[D_WAKE];
        flag_set[F_RING] =  db_lvl[D_RING];
        flag_set[F_RTC]  =  rtc_evt;
        flag_set[F_PF]   = !db_lvl[D_ADOK];
        flag_set[F_WARM] = !db_lvl[D_WARM];
        flag_set[F_WDT]  =  wdt_evt;
        flag_set[F_HS]   =  ro_sync[NUM_RO-1];
    end

    assign flag_clr = wr ? reg_wdata[FLG_HI:FLG_LO] : '0;

    // sticky flags: set dominates a same-cycle write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_set | (flag_q & ~flag_clr);
    end

    // interrupt enables, plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= '0;
        else if (wr) en_q <= reg_wdata[EN_HI:EN_LO];
    end

    // warm-reset request pulse from the write-only bit
    pm_rst_stretch #(.PULSE_CYCLES(PULSE_CYCLES)) u_stretch (
        .clk(clk), .rst_n(rst_n),
        .trig(wr && reg_wdata[BIT_WARMREQ]),
        .req_n(warm_rst_req_n)
    );

    // maskable sources, in enable-bit order (hs, pf, rtc, ring, wake)
    assign irq_src = {flag_q[F_HS], flag_q[F_PF], flag_q[F_RTC],
                      flag_q[F_RING], flag_q[F_WAKE]};
    assign cpu_irq = |(irq_src & en_q);

    // assemble the read word; reserved and write-only bits read zero
    always_comb begin
        word                = '0;
        word[EN_HI:EN_LO]   = en_q;
        word[FLG_HI:FLG_LO] = flag_q;
        word[NUM_PLL:0]     = ro_sync[NUM_PLL:0];
    end

    assign reg_rdata = reg_en ? word : '0;
endmodule

// File: rtl/pm_event_reg_chk.sv
// Module: temporal checks on the power-management register, bound to it.
module pm_event_reg_chk
    import pm_evt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reg_en,
    input logic               reg_we,
    input logic [REG_W-1:0]   reg_wdata,
    input logic               cpu_irq,
    input logic               warm_rst_req_n,
    input logic [NUM_EN-1:0]  en_q,
    input logic [NUM_FLG-1:0] flag_q
);
    logic wr;
    assign wr = reg_en && reg_we;

    // R3: without a write no flag ever falls
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R2: enables change only on a write
    assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(en_q));

    // R7: writing all enables to zero silences the interrupt next cycle
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && reg_wdata[EN_HI:EN_LO] == '0) |=> !cpu_irq);

    // R9: the request falls only right after a write of bit 16
    assert_req_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warm_rst_req_n) |-> $past(wr && reg_wdata[BIT_WARMREQ]));

    // R9: idle request stays idle unless triggered
    assert_req_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst_req_n && !(wr && reg_wdata[BIT_WARMREQ])) |=> warm_rst_req_n);
endmodule

bind pm_event_reg pm_event_reg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .cpu_irq(cpu_irq),
    .warm_rst_req_n(warm_rst_req_n), .en_q(en_q), .flag_q(flag_q)
);

// File: tb/tb_pm_event_reg.sv
`timescale 1ns/1ps
module tb_pm_event_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hotsync_pin = 1'b0, adaptor_ok_pin = 1'b1, ring_pin = 1'b0;
    logic        wake_n_pin = 1'b1, warm_n_pin = 1'b1;
    logic        rtc_evt = 1'b0, wdt_evt = 1'b0;
    logic [2:0]  pll_lock = '0;
    logic        por_stat = 1'b0;
    logic        cpu_irq, warm_rst_req_n;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pm_event_reg dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_read(output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_sync(input bit is_rtc);
        @(negedge clk);
        if (is_rtc) rtc_evt = 1'b1; else wdt_evt = 1'b1;
        @(negedge clk);
        rtc_evt = 1'b0; wdt_evt = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_write(32'h0001_FFF0);
        pulse_sync(1'b0);
        do_reset();
        bus_read(d);
        chk(d[15:4] == 0, "R1 enables/flags after reset", d, 0);
        chk(!cpu_irq && warm_rst_req_n, "R1 irq/req after reset", {cpu_irq, warm_rst_req_n}, 32'h1);
    endtask

    task automatic t_enables();
        logic [31:0] d;
        bus_write(32'h0000_A800);
        repeat (3) @(negedge clk);
        bus_read(d);
        chk(d[15:11] == 5'b10101, "R2 enable pattern A", d[15:11], 5'b10101);
        bus_write(32'h0000_5000);
        bus_read(d);
        chk(d[15:11] == 5'b01010, "R2 enable pattern B", d[15:11], 5'b01010);
        bus_write(32'h0);
    endtask

    task automatic t_sticky_w1c();
        logic [31:0] d;
        pulse_sync(1'b1);
        pulse_sync(1'b0);
        repeat (4) @(negedge clk);
        bus_read(d);
        chk(d[10:4] == 7'b0100100, "R3 rtc+wdt sticky", d[10:4], 7'b0100100);
        bus_write(32'h0000_0000);
        bus_read(d);
        chk(d[10:4] == 7'b0100100, "R4 write zero keeps flags", d[10:4], 7'b0100100);
        bus_write(32'h0000_0040);
        bus_read(d);
        chk(d[10:4] == 7'b0100000, "R4 clear rtc only", d[10:4], 7'b0100000);
        bus_write(32'h0000_0200);
        bus_read(d);
        chk(d[10:4] == 0, "R4 clear wdt", d[10:4], 0);
        // hot-sync: level through synchronizer only
        @(negedge clk); hotsync_pin = 1'b1;
        @(negedge clk); hotsync_pin = 1'b0;
        repeat (5) @(negedge clk);
        bus_read(d);
        chk(d[10] == 1'b1, "R3 hot-sync flag", d[10], 1);
        bus_write(32'h0000_0400);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk); ring_pin = 1'b1;
        repeat (12) @(negedge clk);
        bus_write(32'h0000_0020);
        bus_read(d);
        chk(d[5] == 1'b1, "R5 set beats clear", d[5], 1);
        @(negedge clk); ring_pin = 1'b0;
        repeat (12) @(negedge clk);
        bus_write(32'h0000_0020);
        bus_read(d);
        chk(d[5] == 1'b0, "R5 clear after event gone", d[5], 0);
    endtask

    task automatic t_debounce();
        logic [31:0] d;
        @(negedge clk); ring_pin = 1'b1;
        repeat (3) @(negedge clk);
        ring_pin = 1'b0;
        repeat (12) @(negedge clk);
        bus_read(d);
        chk(d[5] == 1'b0, "R6 three-cycle glitch rejected", d[5], 0);
        @(negedge clk); ring_pin = 1'b1;
        repeat (4) @(negedge clk);
        ring_pin = 1'b0;
        repeat (12) @(negedge clk);
        bus_read(d);
        chk(d[5] == 1'b1, "R6 four-cycle level accepted", d[5], 1);
        bus_write(32'h0000_0020);
    endtask

    task automatic t_irq_level();
        logic [31:0] d;
        @(negedge clk); adaptor_ok_pin = 1'b0;
        repeat (5) @(negedge clk);
        adaptor_ok_pin = 1'b1;
        repeat (12) @(negedge clk);
        bus_read(d);
        chk(d[7] == 1'b1, "R13 power-fail flag", d[7], 1);
        chk(!cpu_irq, "R7 masked flag no irq", cpu_irq, 0);
        bus_write(32'h0000_4000);
        chk(cpu_irq, "R7 enable on latched flag raises irq", cpu_irq, 1);
        bus_write(32'h0000_4080);
        chk(!cpu_irq, "R7 clear drops irq", cpu_irq, 0);
        @(negedge clk); wake_n_pin = 1'b0;
        repeat (5) @(negedge clk);
        wake_n_pin = 1'b1;
        repeat (12) @(negedge clk);
        bus_read(d);
        chk(d[4] == 1'b1, "R13 wake flag", d[4], 1);
        bus_write(32'h0000_0800);
        chk(cpu_irq, "R7 wake enabled irq", cpu_irq, 1);
        bus_write(32'h0000_0000);
        chk(!cpu_irq, "R7 disable drops irq", cpu_irq, 0);
        bus_write(32'h0000_0010);
    endtask

    task automatic t_reset_cause_no_irq();
        logic [31:0] d;
        pulse_sync(1'b0);
        @(negedge clk); warm_n_pin = 1'b0;
        repeat (5) @(negedge clk);
        warm_n_pin = 1'b1;
        repeat (12) @(negedge clk);
        bus_write(32'h0000_F800);
        bus_read(d);
        chk(d[9:8] == 2'b11, "R3 wdt+warm flags", d[9:8], 3);
        chk(!cpu_irq, "R8 reset causes never interrupt", cpu_irq, 0);
        bus_write(32'h0);
    endtask

    task automatic t_warm_req();
        logic [31:0] d;
        int low_cnt;
        bus_write(32'h0);
        chk(warm_rst_req_n, "R9 write zero no request", warm_rst_req_n, 1);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_wdata = 32'h0001_0000;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        low_cnt = 0;
        for (int i = 0; i < 8; i++) begin
            if (!warm_rst_req_n) low_cnt++;
            @(negedge clk);
        end
        chk(low_cnt == 8, "R9 request low cycles", low_cnt, 8);
        chk(warm_rst_req_n, "R9 request released", warm_rst_req_n, 1);
        bus_read(d);
        chk(d[16] == 1'b0, "R9 bit16 reads zero", d[16], 0);
        chk(d[9:8] == 2'b11, "R12 flags survive warm request", d[9:8], 3);
        do_reset();
        bus_read(d);
        chk(d[9:8] == 2'b00, "R12 power-on reset clears", d[9:8], 0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        @(negedge clk); pll_lock = 3'b101; por_stat = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(d);
        chk(d[3:0] == 4'b1011, "R10 pll/por pattern A", d[3:0], 4'b1011);
        bus_write(32'hFFFE_000F & 32'hFFFE_0000);
        bus_write(32'h0000_0000);
        @(negedge clk); pll_lock = 3'b010; por_stat = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(d);
        chk(d[3:0] == 4'b0100, "R10 pll/por pattern B", d[3:0], 4'b0100);
        bus_write(32'hFFFE_0000);
        bus_read(d);
        chk(d[31:17] == 0, "R11 reserved bits zero", d[31:17], 0);
        chk(d[15:4] == 0, "R11 reserved write no side effect", d[15:4], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enables();
        t_sticky_w1c();
        t_set_wins();
        t_debounce();
        t_irq_level();
        t_reset_cause_no_irq();
        t_warm_req();
        t_readonly();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule